// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request (bus number, device/function number and register offset) into the two values a host bridge needs to run a PCI configuration cycle through a 16 MB translation window. One value is the 24-bit offset to use inside that window. The other is a 16-bit map word: its upper twelve bits supply PCI address bits 31:20 (map bit k stands for PCI address bit k+16), bits 3:1 carry the cycle type and bit 0 says whether PCI address bits 1:0 come from the host access.

Requests on bus 0 produce the type 0 format, where the target device is chosen by a single device-select address bit. That bit is slot+11. Slots whose bit falls inside the 24-bit window place it in the window offset. Higher slots place it in the map word. Requests on any other bus produce the type 1 format, which carries bus, device and function as binary fields. Requests that cannot be encoded raise an error flag. A request strobe starts the encoding, and the result comes back one cycle later with a done pulse. Running the PCI transaction itself is left to other logic.

Top module: `cfg_addr_gen`

## Requirements
- R1: `done` is high for exactly the one cycle after each cycle in which `req_valid` is high, and low otherwise; back-to-back requests give back-to-back results.
- R2: A request with `req_bus` equal to 0 gives a type 0 result, with map bit 0 = 0. A request with any other legal bus gives a type 1 result, with map bit 0 = 1.
- R3: In a type 0 result, window bits 10:8 hold the function number (`req_devfn` bits 2:0) and window bits 7:0 hold the register offset.
- R4: In a type 0 result for slot s = `req_devfn` bits 7:3 with s from 0 to 12, exactly window bit s+11 is set among window bits 23:11, and map bits 15:4 are zero.
- R5: In a type 0 result for slot s from 13 to 20, exactly map bit s-5 is set among map bits 15:4, and window bits 23:11 are zero.
- R6: In a type 1 result, the window offset is bus in bits 23:16, devfn in bits 15:8 (slot in 15:11, function in 10:8) and offset in bits 7:0. Map bits 15:4 are zero.
- R7: Every non-error result has the configuration cycle code 3'b101 in map bits 3:1, so the map word is 16'h000A plus any select bit for type 0, and 16'h000B for type 1.
- R8: If `req_bus`, `req_devfn` or `req_offset` is greater than 255, the result has `err` = 1 and the window offset and map word are zero.
- R9: A type 0 request whose slot is greater than 20 gives `err` = 1, no device-select bit, and a zero window offset and map word. On a nonzero bus, slots 21 to 31 are legal.
- R10: While `rst` is high and after it, until the first request, `done` and `err` are 0 and the window offset and map word are zero.
- R11: Between requests, `win_offset`, `map_word` and `err` hold the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_bus | input | ID_W (10) | Bus number; values above 255 are illegal |
| req_devfn | input | ID_W (10) | Device/function number (slot in 7:3, function in 2:0) |
| req_offset | input | ID_W (10) | Register offset in configuration space |
| win_offset | output | 24 | Offset inside the 16 MB configuration window |
| map_word | output | 16 | Map word: upper address bits, cycle type, low-address enable |
| done | output | 1 | One-cycle pulse when a result is presented |
| err | output | 1 | Request could not be encoded |

## Verification
The hardest situation to reach is the seam in the type 0 device select. Slot 12 still lands in the top window bit. Slot 13 must move to map bit 8. Slot 20 is the last slot that can be encoded, and slot 21 must fail. A mistake at any of these edges only shows up for one devfn value. The stimulus therefore sweeps all 32 slots on bus 0 with a changing function and offset, and then repeats the high slots on a nonzero bus, where they must stay legal. Range errors are hit on each field on its own, at 255 and at 256, and issued back to back so that a stale error or value from the previous request would be caught.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;
  // Width of the offset inside the configuration window (16 MB)
  localparam int WIN_W     = 24;
  // Width of the map word
  localparam int MAP_W     = 16;
  // PCI address bit represented by map word bit 0
  localparam int MAP_SHIFT = 16;
  // Lowest PCI address bit used for type 0 device select
  localparam int DEV_LSB   = 11;
  // Slot and function field widths inside devfn
  localparam int SLOT_W    = 5;
  localparam int FUNC_W    = 3;
  localparam int FIELD_W   = 8;
  // Cycle type code for configuration accesses, placed in map bits 3:1
  localparam logic [2:0] CYC_CONFIG = 3'b101;

  typedef struct packed {
    logic [WIN_W-1:0] win;
    logic [MAP_W-1:0] map;
    logic             err;
  } cfg_result_t;
endpackage

// File: rtl/cfg_range_check.sv
module cfg_range_check #(
  parameter int ID_W        = 10,
  parameter int FIELD_LIMIT = 255
) (
  input  logic [ID_W-1:0] bus_i,
  input  logic [ID_W-1:0] devfn_i,
  input  logic [ID_W-1:0] offset_i,
  output logic            range_err_o
);
  localparam int NFIELD = 3;

  logic [NFIELD-1:0][ID_W-1:0] fields;
  logic [NFIELD-1:0]           over;

  assign fields = {bus_i, devfn_i, offset_i};

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    assign over[f] = fields[f] > ID_W'(FIELD_LIMIT);
  end

  assign range_err_o = |over;
endmodule

// File: rtl/cfg_type0_build.sv
module cfg_type0_build
  import cfg_addr_pkg::*;
#(
  parameter int SPLIT_SLOT = 12,
  parameter int TOP_SLOT   = 20
) (
  input  logic [FIELD_W-1:0] devfn_i,
  input  logic [FIELD_W-1:0] offset_i,
  output logic [WIN_W-1:0]   win_o,
  output logic [MAP_W-1:0]   map_o,
  output logic               slot_err_o
);
  localparam int NSEL = TOP_SLOT + 1;

  logic [SLOT_W-1:0] slot;
  logic [FUNC_W-1:0] func;
  logic [NSEL-1:0]   sel;
  logic [WIN_W-1:0]  win_dev;
  logic [MAP_W-1:0]  map_dev;

  assign slot = devfn_i[FUNC_W +: SLOT_W];
  assign func = devfn_i[FUNC_W-1:0];

  // One decoder output per slot that can be encoded
  for (genvar s = 0; s < NSEL; s++) begin : g_sel
    assign sel[s] = (slot == SLOT_W'(s));
  end

  // Low slots land in the window offset at bit slot+DEV_LSB
  for (genvar b = 0; b < WIN_W; b++) begin : g_win
    if (b >= DEV_LSB && (b - DEV_LSB) <= SPLIT_SLOT) begin : g_dev
      assign win_dev[b] = sel[b - DEV_LSB];
    end else begin : g_zero
      assign win_dev[b] = 1'b0;
    end
  end

  // High slots land in the map word; map bit b is PCI address bit b+MAP_SHIFT
  for (genvar b = 0; b < MAP_W; b++) begin : g_map
    localparam int SLOT_OF_B = b + MAP_SHIFT - DEV_LSB;
    if (SLOT_OF_B > SPLIT_SLOT && SLOT_OF_B <= TOP_SLOT) begin : g_dev
      assign map_dev[b] = sel[SLOT_OF_B];
    end else begin : g_zero
      assign map_dev[b] = 1'b0;
    end
  end

  assign slot_err_o = slot > SLOT_W'(TOP_SLOT);

  always_comb begin
    win_o = win_dev;
    win_o[FIELD_W +: FUNC_W] = func;
    win_o[FIELD_W-1:0]       = offset_i;
    map_o = map_dev;
    map_o[3:1] = CYC_CONFIG;
    map_o[0]   = 1'b0;
  end
endmodule

// File: rtl/cfg_type1_build.sv
module cfg_type1_build
  import cfg_addr_pkg::*;
(
  input  logic [FIELD_W-1:0] bus_i,
  input  logic [FIELD_W-1:0] devfn_i,
  input  logic [FIELD_W-1:0] offset_i,
  output logic [WIN_W-1:0]   win_o,
  output logic [MAP_W-1:0]   map_o
);
  always_comb begin
    win_o = '0;
    win_o[2*FIELD_W +: FIELD_W] = bus_i;
    win_o[FIELD_W   +: FIELD_W] = devfn_i;
    win_o[0         +: FIELD_W] = offset_i;
    map_o = '0;
    map_o[3:1] = CYC_CONFIG;
    map_o[0]   = 1'b1;
  end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import cfg_addr_pkg::*;
#(
  parameter int ID_W        = 10,
  parameter int FIELD_LIMIT = 255,
  parameter int SPLIT_SLOT  = 12,
  parameter int TOP_SLOT    = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [ID_W-1:0]        req_bus,
  input  logic [ID_W-1:0]        req_devfn,
  input  logic [ID_W-1:0]        req_offset,
  output logic [WIN_W-1:0]       win_offset,
  output logic [MAP_W-1:0]       map_word,
  output logic                   done,
  output logic                   err
);
  logic             range_err;
  logic             slot_err;
  logic             is_type0;
  logic [WIN_W-1:0] t0_win, t1_win;
  logic [MAP_W-1:0] t0_map, t1_map;
  cfg_result_t      nxt, res_q;
  logic             done_q;

  cfg_range_check #(.ID_W(ID_W), .FIELD_LIMIT(FIELD_LIMIT)) u_range (
    .bus_i      (req_bus),
    .devfn_i    (req_devfn),
    .offset_i   (req_offset),
    .range_err_o(range_err)
  );

  cfg_type0_build #(.SPLIT_SLOT(SPLIT_SLOT), .TOP_SLOT(TOP_SLOT)) u_t0 (
    .devfn_i   (req_devfn[FIELD_W-1:0]),
    .offset_i  (req_offset[FIELD_W-1:0]),
    .win_o     (t0_win),
    .map_o     (t0_map),
    .slot_err_o(slot_err)
  );

  cfg_type1_build u_t1 (
    .bus_i   (req_bus[FIELD_W-1:0]),
    .devfn_i (req_devfn[FIELD_W-1:0]),
    .offset_i(req_offset[FIELD_W-1:0]),
    .win_o   (t1_win),
    .map_o   (t1_map)
  );

  assign is_type0 = (req_bus == '0);

  always_comb begin
    nxt.err = range_err | (is_type0 & slot_err);
    if (nxt.err) begin
      nxt.win = '0;
      nxt.map = '0;
    end else if (is_type0) begin
      nxt.win = t0_win;
      nxt.map = t0_map;
    end else begin
      nxt.win = t1_win;
      nxt.map = t1_map;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= req_valid;
      if (req_valid) res_q <= nxt;
    end
  end

  assign win_offset = res_q.win;
  assign map_word   = res_q.map;
  assign err        = res_q.err;
  assign done       = done_q;

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done); // R1
  AST_TYPE_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
    req_valid && !range_err |=> err || (map_word[0] == ($past(req_bus) != '0))); // R2
  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    done && !err && !map_word[0] |->
      $countones({map_word[MAP_W-1:4], win_offset[WIN_W-1:DEV_LSB]}) == 1); // R4
  AST_CONFIG_CODE: assert property (@(posedge clk) disable iff (rst)
    done && !err |-> map_word[3:1] == CYC_CONFIG); // R7
  AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    err |-> win_offset == '0 && map_word == '0); // R8
  AST_RANGE_ERR: assert property (@(posedge clk) disable iff (rst)
    req_valid && range_err |=> err); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(win_offset) && $stable(map_word) && $stable(err)); // R11
endmodule

// File: tb/tb_cfg_addr_gen.sv
module tb_cfg_addr_gen;
  localparam int ID_W = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [ID_W-1:0] req_bus = '0, req_devfn = '0, req_offset = '0;
  logic [23:0]     win_offset;
  logic [15:0]     map_word;
  logic            done, err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [40:0] exp_q[$];
  string       tag_q[$];

  cfg_addr_gen #(.ID_W(ID_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .win_offset(win_offset), .map_word(map_word), .done(done), .err(err)
  );

  always #5 clk = ~clk;

  // Expected result {err, win, map} computed from the requirements
  function automatic logic [40:0] model(int bus, int devfn, int ofs);
    logic [23:0] w;
    logic [15:0] m;
    int slot;
    if (bus > 255 || devfn > 255 || ofs > 255) return {1'b1, 24'h0, 16'h0}; // R8
    if (bus == 0) begin
      slot = devfn >> 3;
      if (slot > 20) return {1'b1, 24'h0, 16'h0};                           // R9
      w = 24'((devfn & 7) << 8) | 24'(ofs);                                   // R3
      m = 16'h000A;                                                          // R7
      if (slot <= 12) w = w | (24'h1 << (slot + 11));                        // R4
      else            m = m | (16'h1 << (slot - 5));                         // R5
    end else begin
      w = 24'(bus << 16) | 24'(devfn << 8) | 24'(ofs);                        // R6
      m = 16'h000B;                                                          // R2
    end
    return {1'b0, w, m};
  endfunction

  task automatic check(string tag, logic [40:0] act, logic [40:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual err=%0b win=%06h map=%04h, expected err=%0b win=%06h map=%04h",
               tag, act[40], act[39:16], act[15:0], exp[40], exp[39:16], exp[15:0]);
    end
  endtask

  task automatic send(int bus, int devfn, int ofs, string tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_bus    = ID_W'(bus);
    req_devfn  = ID_W'(devfn);
    req_offset = ID_W'(ofs);
    exp_q.push_back(model(bus, devfn, ofs));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears (R1)
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R1: actual done=1 with no request, expected done=0");
      end else begin
        logic [40:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {err, win_offset, map_word}, e);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual run not finished, expected finish");
    summary();
  end

  initial begin : main
    logic [40:0] last;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset", {err, win_offset, map_word}, 41'h0);
    n_checks++;
    if (done !== 1'b0) begin n_fail++; $display("FAIL R10: actual done=%0b expected 0", done); end
    rst = 1'b0;
    idle(2);
    check("R10 after reset", {err, win_offset, map_word}, 41'h0);

    send(0, 8'h00, 0,   "R3 R4 slot0");
    send(0, 8'h65, 8'h3C, "R3 R4 slot12 fn5");
    send(0, 8'h6B, 8'h10, "R5 slot13 fn3");
    send(0, 8'hA7, 8'hFF, "R5 slot20 fn7");
    send(0, 8'hA8, 8'h04, "R9 slot21");
    send(0, 8'hFF, 8'h00, "R9 slot31");
    idle(2);
    // Full slot sweep on bus 0, function and offset varying
    for (int s = 0; s < 32; s++) send(0, s * 8 + (s % 8), (s * 9) & 255, "R4 R5 R9 sweep");
    idle(1);
    send(1, 8'h3A, 8'h44,  "R6 R2 bus1");
    send(255, 8'hFF, 8'hFF, "R6 bus255 max");
    send(7, 8'hA8, 8'h00,  "R6 R9 type1 slot21 legal");
    send(3, 8'hF9, 8'h80,  "R6 type1 slot31 legal");
    send(256, 8'h08, 8'h00, "R8 bus256");
    send(0, 256, 8'h00,    "R8 devfn256");
    send(2, 8'h10, 256,    "R8 offset256");
    send(0, 8'h08, 255,    "R8 R3 offset255 legal");
    send(1023, 1023, 1023, "R8 all over");
    send(0, 8'h30, 8'h20,  "R7 after error");
    idle(1);
    // Hold between requests
    send(4, 8'h55, 8'h66, "R11 setup");
    last = model(4, 8'h55, 8'h66);
    idle(1);
    for (int i = 0; i < 3; i++) begin
      req_bus = ID_W'(0); req_devfn = ID_W'(300); req_offset = ID_W'(i);
      @(negedge clk);
      check("R11 hold", {err, win_offset, map_word}, last);
    end
    send(0, 8'hA8, 8'h00, "R11 setup err");
    idle(1);
    req_bus = ID_W'(5);
    repeat (2) @(negedge clk);
    check("R11 hold err", {err, win_offset, map_word}, {1'b1, 40'h0});
    idle(3);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: actual %0d results missing, expected 0", exp_q.size());
    end
    summary();
  end
endmodule